// File: doc/BRIEF.md
# Banked Byte-Wide Static Memory

This block is a functional model of a byte-wide static memory built out of several identical smaller banks. The address is split in two: the upper bits pick one bank through a one-hot decoder, and the lower bits pick a word inside that bank. Every bank that is not picked stays idle, and when the module is deselected no bank is enabled at all. Access follows level-sensitive rules on three active-low pins (module select, output enable, write enable), not a transfer clock. A write is open while select and write enable are both low, and it is committed when either of them rises. A read drives the addressed byte while select and output enable are low and write enable is high.

The pins are observed on a fast sampling clock, so the model can be synthesized and checked. The bidirectional data bus is split into a data-in port, a data-out port and a bus-drive flag; a pad ring outside the block joins them into a tristate pin. The bank count and the bank depth are parameters. A debug output reports which bank is active, or an idle code while the module is deselected.

Top module: `sram_bank_array`

## Requirements
- R1: A write is open on every sampled cycle where `msN` and `weN` are both 0. It is committed into the memory on the first clock edge at which that overlap is no longer present, and only once.
- R2: An open write that ends because `weN` returns to 1 stores the byte at the address held during the overlap.
- R3: An open write that ends because `msN` returns to 1 also stores the byte, exactly as in R2.
- R4: The byte and the address stored are the ones present on the last sampled cycle of the overlap. A data value that is replaced earlier during the same overlap is lost.
- R5: While `msN`=0, `oeN`=0 and `weN`=1, `dataOe` is 1 and `dataOut` shows the byte stored at `addr` in the same cycle, with no clock edge in between.
- R6: In every other combination of `msN`, `oeN` and `weN`, `dataOe` is 0 and `dataOut` is all zeros.
- R7: `addr[WORD_W-1:0]` selects the word and `addr[ADDR_W-1:WORD_W]` selects the bank (with the defaults, bits 3..0 give the word and bits 5..4 give the bank). All BANKS×DEPTH locations hold independent values, with no aliasing.
- R8: `activeBank` equals the bank-index field of `addr` while `msN`=0. It is all ones (7 with the defaults) while `msN`=1.
- R9: At most one bank is enabled at any time, and none is enabled while `msN`=1.
- R10: While `rstN`=0, `dataOe`=0 and an open write is dropped. A write whose overlap was cut short by reset leaves the location unchanged.
- R11: `oeN` has no effect on writes. With `oeN`=0 during the overlap the write still completes, and the bus stays undriven throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the control pins and the memory write port |
| rstN | input | 1 | Asynchronous active-low reset of the write-tracking state |
| addr | input | ADDR_W | Word address; upper field selects the bank |
| msN | input | 1 | Active-low module select |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| dataIn | input | WIDTH | Byte presented to the memory by the bus |
| dataOut | output | WIDTH | Byte driven toward the bus; zero when not driving |
| dataOe | output | 1 | High when the block drives the data bus |
| activeBank | output | BSEL_W+1 | Index of the enabled bank, all ones when deselected |

## Verification
The hardest situations to reach from the ports are the end of a write and the choice of which data it keeps. A write has no strobe of its own: it commits only when the select/write-enable overlap collapses. The stimulus therefore closes overlaps in both ways: sometimes by raising write enable, sometimes by raising select. It also replaces the data in the middle of an overlap, and it cuts one overlap short with reset before it can end. Afterwards each location is read back against a model filled with a distinct pattern across every bank, so a misrouted or lost commit shows up at the data port.

// File: rtl/sbk_pkg.sv
package sbk_pkg;

  // Strobes handed from the pin-control logic to the datapath.
  typedef struct packed {
    logic sel;     // module selected: bank decoder may enable a bank
    logic latch;   // write overlap present: hold address and byte
    logic commit;  // overlap just closed: store the held byte
    logic drive;   // read conditions met: put the byte on the bus
  } sbkStrobe_t;

  localparam sbkStrobe_t STROBE_IDLE = '{sel: 1'b0, latch: 1'b0, commit: 1'b0, drive: 1'b0};

endpackage

// File: rtl/sbk_decoder.sv
module sbk_decoder #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          en,
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  hot
);

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_line
      assign hot[gi] = en && (idx == IW'(gi));
    end
  endgenerate

endmodule

// File: rtl/sbk_bank.sv
module sbk_bank #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 8,
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrWord,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [WORD_W-1:0] rdWord,
  output logic [WIDTH-1:0]  rdData
);

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) begin
      cells[wrWord] <= wrData;
    end
  end

  assign rdData = cells[rdWord];

endmodule

// File: rtl/sbk_ctrl.sv
module sbk_ctrl
  import sbk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       msN,
  input  logic       oeN,
  input  logic       weN,
  output sbkStrobe_t strb
);

  logic overlapNow;
  logic wrOpenQ;

  assign overlapNow = !msN && !weN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrOpenQ <= 1'b0;
    end else begin
      wrOpenQ <= overlapNow;
    end
  end

  always_comb begin
    strb        = STROBE_IDLE;
    strb.sel    = !msN;
    strb.latch  = overlapNow;
    strb.commit = wrOpenQ && !overlapNow && rstN;
    strb.drive  = !msN && !oeN && weN && rstN;
  end

  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !strb.commit); // R1

  AST_NO_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.latch |-> !strb.drive); // R11

endmodule

// File: rtl/sbk_datapath.sv
module sbk_datapath
  import sbk_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 8,
  parameter int WORD_W = 4,
  parameter int BSEL_W = 2,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbkStrobe_t        strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  dataIn,
  output logic [WIDTH-1:0]  dataOut,
  output logic              dataOe,
  output logic [BSEL_W:0]   activeBank
);

  logic [ADDR_W-1:0] wrAddrQ;
  logic [WIDTH-1:0]  wrDataQ;
  logic [BANKS-1:0]  bankEn;
  logic [BANKS-1:0]  bankWe;
  logic [WIDTH-1:0]  rdArr [BANKS];
  logic [WIDTH-1:0]  rdSel;

  // Address and byte of the open write, refreshed every overlap cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddrQ <= '0;
      wrDataQ <= '0;
    end else if (strb.latch) begin
      wrAddrQ <= addr;
      wrDataQ <= dataIn;
    end
  end

  sbk_decoder #(.N(BANKS), .IW(BSEL_W)) rdDec_i (
    .en  (strb.sel),
    .idx (addr[ADDR_W-1:WORD_W]),
    .hot (bankEn)
  );

  sbk_decoder #(.N(BANKS), .IW(BSEL_W)) wrDec_i (
    .en  (strb.commit),
    .idx (wrAddrQ[ADDR_W-1:WORD_W]),
    .hot (bankWe)
  );

  genvar gb;
  generate
    for (gb = 0; gb < BANKS; gb++) begin : g_bank
      sbk_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH), .WORD_W(WORD_W)) bank_i (
        .clk    (clk),
        .wrEn   (bankWe[gb]),
        .wrWord (wrAddrQ[WORD_W-1:0]),
        .wrData (wrDataQ),
        .rdWord (addr[WORD_W-1:0]),
        .rdData (rdArr[gb])
      );
    end
  endgenerate

  // Idle banks contribute nothing to the read path.
  always_comb begin
    rdSel = '0;
    for (int i = 0; i < BANKS; i++) begin
      if (bankEn[i]) begin
        rdSel = rdSel | rdArr[i];
      end
    end
  end

  assign dataOe     = strb.drive;
  assign dataOut    = strb.drive ? rdSel : '0;
  assign activeBank = strb.sel ? {1'b0, addr[ADDR_W-1:WORD_W]} : '1;

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankEn)); // R9

  AST_IDLE_NO_BANK: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sel |-> (bankEn == '0)); // R9

  AST_ONE_WRITE_BANK: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankWe)); // R7

endmodule

// File: rtl/sram_bank_array.sv
module sram_bank_array
  import sbk_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int WORD_W = $clog2(DEPTH),
  localparam int BSEL_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int ADDR_W = WORD_W + BSEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              msN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [WIDTH-1:0]  dataIn,
  output logic [WIDTH-1:0]  dataOut,
  output logic              dataOe,
  output logic [BSEL_W:0]   activeBank
);

  sbkStrobe_t strb;

  sbk_ctrl ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .msN  (msN),
    .oeN  (oeN),
    .weN  (weN),
    .strb (strb)
  );

  sbk_datapath #(
    .BANKS(BANKS), .DEPTH(DEPTH), .WIDTH(WIDTH),
    .WORD_W(WORD_W), .BSEL_W(BSEL_W), .ADDR_W(ADDR_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .addr       (addr),
    .dataIn     (dataIn),
    .dataOut    (dataOut),
    .dataOe     (dataOe),
    .activeBank (activeBank)
  );

  AST_COMMIT_AFTER_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> ($past(!msN && !weN) && (msN || weN))); // R1

  AST_BUS_OFF_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> !dataOe); // R6

  AST_BUS_OFF_DESEL: assert property (@(posedge clk) disable iff (!rstN)
    msN |-> (!dataOe && dataOut == '0)); // R6

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    msN |-> (activeBank == '1)); // R8

endmodule

// File: tb/sram_bank_array_tb_top.sv
module sram_bank_array_tb_top;

  localparam int BANKS  = 4;
  localparam int DEPTH  = 16;
  localparam int WIDTH  = 8;
  localparam int WORD_W = 4;
  localparam int BSEL_W = 2;
  localparam int ADDR_W = 6;
  localparam int LOCS   = BANKS * DEPTH;
  localparam logic [BSEL_W:0] IDLE_CODE = '1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              msN = 1'b1;
  logic              oeN = 1'b1;
  logic              weN = 1'b1;
  logic [WIDTH-1:0]  dataIn = '0;
  logic [WIDTH-1:0]  dataOut;
  logic              dataOe;
  logic [BSEL_W:0]   activeBank;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [WIDTH-1:0] model [LOCS];

  typedef struct {
    logic [ADDR_W-1:0] a;
    logic [WIDTH-1:0]  d;
    logic [BSEL_W:0]   b;
    string             tag;
  } expItem_t;

  expItem_t expQ[$];
  bit monArm = 1'b0;

  always #5 clk = ~clk;

  sram_bank_array #(.BANKS(BANKS), .DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .addr       (addr),
    .msN        (msN),
    .oeN        (oeN),
    .weN        (weN),
    .dataIn     (dataIn),
    .dataOut    (dataOut),
    .dataOe     (dataOe),
    .activeBank (activeBank)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected read per armed cycle and compares the bus.
  always @(negedge clk) begin
    if (monArm && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check(dataOe === 1'b1, {it.tag, " R5 drive"}, int'(dataOe), 1);
      check(dataOut === it.d, {it.tag, " R5/R7 data"}, int'(dataOut), int'(it.d));
      check(activeBank === it.b, {it.tag, " R8 bank"}, int'(activeBank), int'(it.b));
    end
  end

  task automatic doWrite(int a, logic [WIDTH-1:0] d, bit endByMs, bit oeLow);
    @(posedge clk); #1;
    addr = ADDR_W'(a); dataIn = d; oeN = !oeLow; msN = 1'b0; weN = 1'b0;
    #1;
    check(dataOe === 1'b0, "R11 bus off during write", int'(dataOe), 0);
    @(posedge clk); #1;
    if (endByMs) msN = 1'b1; else weN = 1'b1;
    @(posedge clk); #1;
    msN = 1'b1; weN = 1'b1; oeN = 1'b1;
    model[a] = d;
  endtask

  task automatic doRead(int a, string tag);
    expItem_t it;
    @(posedge clk); #1;
    addr = ADDR_W'(a); msN = 1'b0; oeN = 1'b0; weN = 1'b1;
    it.a = ADDR_W'(a); it.d = model[a]; it.b = (BSEL_W+1)'(a >> WORD_W); it.tag = tag;
    expQ.push_back(it);
    monArm = 1'b1;
    @(posedge clk); #1;
    monArm = 1'b0; msN = 1'b1; oeN = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    // Reset state (R10)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dataOe === 1'b0, "R10 reset dataOe", int'(dataOe), 0);
    check(dataOut === '0, "R6 reset dataOut", int'(dataOut), 0);
    check(activeBank === IDLE_CODE, "R8 reset idle code", int'(activeBank), int'(IDLE_CODE));
    rstN = 1'b1;

    // Fill every location with a distinct pattern, alternating the ending pin (R2, R3, R7)
    for (int a = 0; a < LOCS; a++) begin
      doWrite(a, WIDTH'(a * 3 + 8'h41), a[0], 1'b0);
    end
    @(negedge clk);
    check(activeBank === IDLE_CODE, "R8 idle after writes", int'(activeBank), int'(IDLE_CODE));
    for (int a = 0; a < LOCS; a++) begin
      doRead(a, (a % 2) ? "R3 end by select" : "R2 end by write enable");
    end

    // Second pattern, oeN held low during writes, read back in reverse (R11, R7)
    for (int a = 0; a < LOCS; a++) begin
      doWrite(a, ~WIDTH'(a * 5 + 8'h17), a[1], 1'b1);
    end
    for (int a = LOCS - 1; a >= 0; a--) begin
      doRead(a, "R11 write with oeN low");
    end

    // Data replaced mid-overlap: last sampled value wins (R4)
    @(posedge clk); #1;
    addr = ADDR_W'(37); dataIn = 8'hA5; msN = 1'b0; weN = 1'b0;
    @(posedge clk); #1;
    dataIn = 8'h3C;
    @(posedge clk); #1;
    weN = 1'b1;
    @(posedge clk); #1;
    msN = 1'b1;
    model[37] = 8'h3C;
    doRead(37, "R4 last data wins");

    // Overlap cut short by reset leaves location unchanged (R10)
    doWrite(22, 8'h11, 1'b0, 1'b0);
    @(posedge clk); #1;
    addr = ADDR_W'(22); dataIn = 8'hEE; msN = 1'b0; weN = 1'b0;
    @(posedge clk); #1;
    rstN = 1'b0; msN = 1'b1; weN = 1'b1;
    @(negedge clk);
    check(dataOe === 1'b0, "R10 dataOe in reset", int'(dataOe), 0);
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    doRead(22, "R10 aborted write dropped");

    // Every control combination at one address per bank (R6, R8, R9)
    for (int b = 0; b < BANKS; b++) begin
      for (int c = 0; c < 8; c++) begin
        int a;
        bit expOe;
        a = b * DEPTH + 9;
        expOe = (c[2] == 1'b0) && (c[1] == 1'b0) && (c[0] == 1'b1);
        @(posedge clk); #1;
        addr = ADDR_W'(a); dataIn = model[a];
        msN = c[2]; oeN = c[1]; weN = c[0];
        @(negedge clk);
        check(dataOe === expOe, "R6 bus drive by combination", int'(dataOe), int'(expOe));
        check(dataOut === (expOe ? model[a] : '0), "R6 bus data by combination",
              int'(dataOut), int'(expOe ? model[a] : 8'h00));
        check(activeBank === (c[2] ? IDLE_CODE : (BSEL_W+1)'(b)), "R8/R9 active bank",
              int'(activeBank), int'(c[2] ? IDLE_CODE : (BSEL_W+1)'(b)));
        @(posedge clk); #1;
        msN = 1'b1; oeN = 1'b1; weN = 1'b1;
        @(posedge clk);
      end
      doRead(b * DEPTH + 9, "R1 combination sweep kept data");
    end

    repeat (3) @(posedge clk);
    check(expQ.size() == 0, "R5 scoreboard drained", expQ.size(), 0);
    finishRun();
  end

endmodule